// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block is the receiving end of a three-wire, write-only serial link. A host lowers an active-low frame select, then sends serial data bits that the block captures on each falling edge of the serial clock. The first bit to arrive is the most significant. Once 24 bits have been taken in, the frame is handed to downstream logic at once, whether or not frame select has risen. Downstream logic treats the upper eight bits as a control byte and the lower sixteen as a data word; this block does not decode either.

The three link inputs are asynchronous to the block's system clock. Each one passes through a two-flop synchronizer, and edges are found by comparing the synchronized value with its value one system clock earlier. The system clock must run at least four times as fast as the serial clock. A frame that frame select ends early is dropped without effect, and a one-cycle strobe reports it so that tests can see it.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, frame_word is all zeros and both frame_valid and frame_aborted are low.
- R2: The first bit captured in a frame ends up in frame_word[23] and the 24th in frame_word[0], so bits 23..16 carry the control byte and bits 15..0 the data word.
- R3: frame_valid pulses high for one system clock, starting three system clocks after the 24th falling serial-clock edge reaches the pins: two synchronizer stages plus one edge-detect stage. Frame select may still be low at that point.
- R4: In the same frame, falling serial-clock edges after the 24th produce no further frame_valid and leave frame_word unchanged.
- R5: If frame select rises before the 24th falling edge, frame_aborted pulses for one cycle, frame_valid stays low and frame_word keeps its previous value.
- R6: If frame select rises after a completed frame, there is no frame_aborted pulse. This holds whether the rise comes at once or after frame select has stayed low for a while.
- R7: Each falling edge of frame select starts a new frame at bit zero, so bits from an aborted frame never reach a later frame.
- R8: If frame select rises in the same synchronized cycle as the 24th falling serial-clock edge, the rise wins: the frame is aborted and nothing is delivered.
- R9: frame_valid and frame_aborted are never high together, and neither stays high for two cycles in a row.
- R10: Serial-clock edges while frame select is high produce no strobe and leave frame_word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_in | input | 1 | Active-low frame select, asynchronous |
| sclk_in | input | 1 | Serial clock; data is sampled on its falling edge |
| sdi_in | input | 1 | Serial data, most significant bit first |
| frame_word | output | 24 | Last completed frame, control byte in bits 23..16 |
| frame_valid | output | 1 | One-cycle strobe when a frame completes |
| frame_aborted | output | 1 | One-cycle strobe when a frame is cut short |

## Verification
Completion of a frame and its abort can both fall in the same system clock. This happens when the 24th falling serial-clock edge and the rise of frame select arrive together at the synchronizers. The bench provokes it by lowering the serial clock and raising frame select in the same instant at the end of bit 24. It judges the result by the strobe counts, expecting one abort and no delivery, and by frame_word, which must keep the prior frame's value.

// File: rtl/serial_frame_rx.sv
`timescale 1ns/1ps
module serial_frame_rx #(
  parameter int WORD_BITS   = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_n_in,
  input  logic                 sclk_in,
  input  logic                 sdi_in,
  output logic [WORD_BITS-1:0] frame_word,
  output logic                 frame_valid,
  output logic                 frame_aborted
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);

  logic [SYNC_STAGES-1:0] sel_pipe, sclk_pipe, sdi_pipe;
  logic                   sel_q, sclk_q;
  logic                   in_frame;
  logic [CNT_W-1:0]       bit_cnt;
  logic [WORD_BITS-1:0]   shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_pipe  <= '1;
      sclk_pipe <= '0;
      sdi_pipe  <= '0;
      sel_q     <= 1'b1;
      sclk_q    <= 1'b0;
    end else begin
      sel_pipe  <= {sel_pipe[SYNC_STAGES-2:0], sel_n_in};
      sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], sclk_in};
      sdi_pipe  <= {sdi_pipe[SYNC_STAGES-2:0], sdi_in};
      sel_q     <= sel_pipe[SYNC_STAGES-1];
      sclk_q    <= sclk_pipe[SYNC_STAGES-1];
    end
  end

  wire sel_s     = sel_pipe[SYNC_STAGES-1];
  wire sel_rise  = !sel_q && sel_s;
  wire sel_fall  = sel_q && !sel_s;
  wire sclk_fall = sclk_q && !sclk_pipe[SYNC_STAGES-1];
  wire full      = (bit_cnt == CNT_W'(WORD_BITS));
  wire last_bit  = (bit_cnt == CNT_W'(WORD_BITS - 1));
  wire take_bit  = in_frame && !full && sclk_fall;
  wire [WORD_BITS-1:0] shreg_nxt = {shreg[WORD_BITS-2:0], sdi_pipe[SYNC_STAGES-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame      <= 1'b0;
      bit_cnt       <= '0;
      shreg         <= '0;
      frame_word    <= '0;
      frame_valid   <= 1'b0;
      frame_aborted <= 1'b0;
    end else begin
      frame_valid   <= 1'b0;
      frame_aborted <= 1'b0;
      if (sel_rise) begin
        frame_aborted <= in_frame && !full;
        in_frame      <= 1'b0;
        bit_cnt       <= '0;
        shreg         <= '0;
      end else if (sel_fall) begin
        in_frame <= 1'b1;
        bit_cnt  <= '0;
        shreg    <= '0;
      end else if (take_bit) begin
        shreg   <= shreg_nxt;
        bit_cnt <= bit_cnt + 1'b1;
        if (last_bit) begin
          frame_word  <= shreg_nxt;
          frame_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_frame_rx_chk.sv
`timescale 1ns/1ps
module serial_frame_rx_chk #(
  parameter int WORD_BITS = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sel_n_in,
  input logic [WORD_BITS-1:0] frame_word,
  input logic                 frame_valid,
  input logic                 frame_aborted
);
  p_valid_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);
  p_abort_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_aborted |=> !frame_aborted);
  p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_valid && frame_aborted));
  p_word_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> $stable(frame_word));
  p_valid_while_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> !$past(sel_n_in, 3));
  p_abort_on_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_aborted |-> $past(sel_n_in, 3));
endmodule

bind serial_frame_rx serial_frame_rx_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n_in(sel_n_in),
  .frame_word(frame_word), .frame_valid(frame_valid), .frame_aborted(frame_aborted)
);

// File: tb/serial_frame_rx_bench.sv
`timescale 1ns/1ps
module serial_frame_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [23:0] frame_word;
  logic frame_valid, frame_aborted;

  always #5 clk = ~clk;

  serial_frame_rx u_serial_frame_rx (
    .clk(clk), .rst_n(rst_n), .sel_n_in(sel_n), .sclk_in(sclk), .sdi_in(sdi),
    .frame_word(frame_word), .frame_valid(frame_valid), .frame_aborted(frame_aborted)
  );

  int n_checks = 0, n_fail = 0;
  int cyc = 0, valid_cnt = 0, abort_cnt = 0, valid_cyc = 0, fall_cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (frame_valid) begin valid_cnt++; valid_cyc = cyc; end
    if (frame_aborted) abort_cnt++;
  end

  // [29] hold select low afterwards, [28:24] bit count, [23:0] word
  localparam logic [31:0] VEC [8] = '{
    {2'b00, 1'b0, 5'd24, 24'h3C8001},
    {2'b00, 1'b0, 5'd24, 24'h800001},
    {2'b00, 1'b0, 5'd28, 24'h123456},
    {2'b00, 1'b0, 5'd10, 24'hDEAD01},
    {2'b00, 1'b0, 5'd24, 24'hA5F00F},
    {2'b00, 1'b0, 5'd0,  24'hFFFFFF},
    {2'b00, 1'b1, 5'd24, 24'h55AAAA},
    {2'b00, 1'b0, 5'd23, 24'h000000}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] w, input int n, input bit keep_low);
    sel_n = 1'b0;
    wclk(4);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 24) ? w[23 - i] : ~w[0];
      sclk = 1'b1; wclk(4);
      sclk = 1'b0;
      if (i == 23) fall_cyc = cyc;
      wclk(4);
    end
    if (keep_low) begin
      wclk(6);
      for (int k = 0; k < 3; k++) begin
        sdi = ~sdi; sclk = 1'b1; wclk(4); sclk = 1'b0; wclk(4);
      end
    end
    sel_n = 1'b1;
    wclk(8);
  endtask

  logic [23:0] exp_word = '0;

  initial begin
    wclk(3);
    rst_n = 1'b1;
    wclk(2);
    check(frame_word == 24'h0, "R1 word after reset", frame_word, 0);
    check(!frame_valid && !frame_aborted, "R1 strobes after reset",
          {frame_valid, frame_aborted}, 0);

    for (int v = 0; v < 8; v++) begin
      int vb, ab, nb;
      bit kl;
      nb = int'(VEC[v][28:24]);
      kl = VEC[v][29];
      vb = valid_cnt; ab = abort_cnt;
      send(VEC[v][23:0], nb, kl);
      if (nb >= 24) begin
        exp_word = VEC[v][23:0];
        check(valid_cnt - vb == 1, "R3 one delivery", valid_cnt - vb, 1);
        check(abort_cnt - ab == 0, "R6 no abort after completion", abort_cnt - ab, 0);
        check(frame_word == exp_word, nb > 24 ? "R4 extra edges ignored" : "R2 word order",
              frame_word, exp_word);
        check(valid_cyc - fall_cyc == 3, "R3 latency", valid_cyc - fall_cyc, 3);
      end else begin
        check(valid_cnt - vb == 0, "R5 no delivery on abort", valid_cnt - vb, 0);
        check(abort_cnt - ab == 1, "R5 abort strobe", abort_cnt - ab, 1);
        check(frame_word == exp_word, "R5 word kept", frame_word, exp_word);
      end
    end

    // R7: abort then full frame, no carry-over of earlier bits
    begin
      int vb;
      send(24'hFFFFFF, 12, 1'b0);
      vb = valid_cnt;
      send(24'h0F0F01, 24, 1'b0);
      exp_word = 24'h0F0F01;
      check(valid_cnt - vb == 1 && frame_word == exp_word, "R7 fresh frame",
            frame_word, exp_word);
    end

    // R8: 24th falling edge and select rise together
    begin
      int vb, ab;
      vb = valid_cnt; ab = abort_cnt;
      sel_n = 1'b0; wclk(4);
      for (int i = 0; i < 24; i++) begin
        sdi = i[0];
        sclk = 1'b1; wclk(4);
        sclk = 1'b0;
        if (i == 23) sel_n = 1'b1;
        wclk(4);
      end
      wclk(8);
      check(valid_cnt - vb == 0, "R8 no delivery", valid_cnt - vb, 0);
      check(abort_cnt - ab == 1, "R8 abort wins", abort_cnt - ab, 1);
      check(frame_word == exp_word, "R8 word kept", frame_word, exp_word);
    end

    // R10: clocking with select high
    begin
      int vb, ab;
      vb = valid_cnt; ab = abort_cnt;
      for (int i = 0; i < 30; i++) begin
        sdi = ~sdi; sclk = 1'b1; wclk(4); sclk = 1'b0; wclk(4);
      end
      wclk(6);
      check(valid_cnt - vb == 0 && abort_cnt - ab == 0, "R10 idle clocks ignored",
            (valid_cnt - vb) + (abort_cnt - ab), 0);
      check(frame_word == exp_word, "R10 word kept", frame_word, exp_word);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule